// File: doc/BRIEF.md
# Double-Data-Rate Burst-of-Two SRAM Core

This block is a synthesizable behavioural model of a synchronous static RAM with a double-data-rate data bus. A controller under test uses it as its memory target. The block runs on one fast clock, and each fast cycle is one half of a main clock period. An output phase flag marks the half. A command is taken only on a main edge, which is a clock edge where the phase flag is low before the edge. Each command moves exactly one array word. That word is twice the bus width, and it crosses the bus as two half-cycle transfers.

Incoming write halves are collected in a demultiplex buffer. The buffer is committed to the array late, at the main edge after the data. A read fetches the whole array word and steers its halves onto the bus one after the other. A one-entry forwarding path keeps reads coherent with a write that is still waiting in the buffer. Each transfer carries its own active-low lane enables, so either half, or both halves, of a write can be masked.

Address bit 0 selects which half moves first. With critical-word-first disabled by parameter, bit 0 is ignored and the low half always goes first.

Top module: `ddr_b2_sram`

## Requirements
- R1: While no read data is due, `dqOe` is 0 and `dqOut` is all zeros. A main edge with `loadN` high starts no operation.
- R2: `halfPhase` is 0 before the first edge after reset and inverts on every clock edge. Commands are sampled only on main edges (`halfPhase` 0 before the edge). `loadN`, `rdWr` and `addr` are ignored on the other edges.
- R3: A write command (`loadN`=0, `rdWr`=0) takes its first data word on the next main edge and its second word on the half edge after that. Both are stored into array word `addr[ADDR_W-1:1]`.
- R4: A read command (`loadN`=0, `rdWr`=1) drives its first word after the next main edge and its second word after the following half edge. `dqOe` is 1 for exactly those two half-cycles, unless another read follows at once.
- R5: With CRIT_FIRST=1, `addr[0]`=0 maps the first transfer to array bits [DATA_W-1:0] and the second transfer to the upper half. `addr[0]`=1 reverses this, for both reads and writes.
- R6: With CRIT_FIRST=0, `addr[0]` has no effect: the first transfer always maps to the low half of the array word.
- R7: Enable bit j of `bwN`, sampled with each transfer, stores bits [j*LANE_W +: LANE_W] of that transfer when it is 0 and leaves them unchanged when it is 1.
- R8: A write whose enables are all 1 in both transfers changes no array bit.
- R9: A read issued on the main edge right after a write to the same array word returns that write's data merged under its lane enables. The same holds when two writes to the same word precede the read.
- R10: Commands on every main edge are accepted back to back with no idle cycle.
- R11: During reset `dqOe` is 0, `dqOut` is 0 and `halfPhase` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock; two edges form one main period |
| rstN | input | 1 | Asynchronous active-low reset |
| loadN | input | 1 | Active-low command strobe, sampled on main edges |
| rdWr | input | 1 | 1 selects read, 0 selects write |
| addr | input | ADDR_W | Bit 0 selects the starting half; upper bits select the array word |
| bwN | input | DATA_W/LANE_W | Active-low lane enables, one per lane, per transfer |
| dqIn | input | DATA_W | Write data bus |
| dqOut | output | DATA_W | Read data bus, zero when released |
| dqOe | output | 1 | Bus drive enable for the read data half-cycles |
| halfPhase | output | 1 | 0 in the first half of a main period, 1 in the second |

## Verification
Edges are counted from the main edge that samples a command. Write data is due on edges 2 and 3. Read data appears after edges 2 and 3. The write is committed at edge 4. The bench applies every input on a falling edge. It checks the second word of the read issued two main periods earlier on the falling edge before a main edge. It checks the first word of the previous read on the falling edge inside the period. Because every result is compared exactly in the half-cycle when it is due, a result one edge early or late fails. Two instances with and without critical-word-first share the same stimulus. Each is compared against its own arithmetic model, which applies writes at issue time. Writes are applied at issue time so that forwarded reads have a known answer.

// File: rtl/ddrb2_pkg.sv
package ddrb2_pkg;
  // Strobes from control to datapath, valid for the coming clock edge.
  typedef struct packed {
    logic rdLoad;    // capture merged array word for the read burst
    logic wrFirst;   // capture first write transfer
    logic wrSecond;  // capture second write transfer
    logic commit;    // write gathered buffer into the array
    logic outSel;    // which half of the read word is on the bus
    logic busOe;     // bus is driven
  } ddrStrobes_t;
endpackage

// File: rtl/ddrb2_ctrl.sv
module ddrb2_ctrl
  import ddrb2_pkg::*;
#(
  parameter int AW         = 7,
  parameter int CRIT_FIRST = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadN,
  input  logic          rdWr,
  input  logic [AW-1:0] addr,
  output ddrStrobes_t   strobes,
  output logic [AW-2:0] idx,
  output logic          slot,
  output logic          halfPhase
);
  localparam int IW = AW - 1;

  logic          phase;
  logic          cmdRd, cmdWr, cmdSlot;
  logic [IW-1:0] cmdIdx;
  logic          wStage, wValid;
  logic          busOe, outSecond, outSlot;
  logic          addrSlot;

  generate
    if (CRIT_FIRST != 0) begin : g_critFirst
      assign addrSlot = addr[0];
    end else begin : g_fixedOrder
      assign addrSlot = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= 1'b0;
      cmdRd     <= 1'b0;
      cmdWr     <= 1'b0;
      cmdSlot   <= 1'b0;
      cmdIdx    <= '0;
      wStage    <= 1'b0;
      wValid    <= 1'b0;
      busOe     <= 1'b0;
      outSecond <= 1'b0;
      outSlot   <= 1'b0;
    end else begin
      phase <= ~phase;
      if (!phase) begin
        // main edge: sample command, advance the pipelines one main period
        cmdRd     <= !loadN && rdWr;
        cmdWr     <= !loadN && !rdWr;
        cmdIdx    <= addr[AW-1:1];
        cmdSlot   <= addrSlot;
        wStage    <= cmdWr;
        wValid    <= 1'b0;
        busOe     <= cmdRd;
        outSecond <= 1'b0;
        outSlot   <= cmdSlot;
      end else begin
        wStage    <= 1'b0;
        wValid    <= wStage;
        outSecond <= 1'b1;
      end
    end
  end

  assign strobes.rdLoad   = !phase && cmdRd;
  assign strobes.wrFirst  = !phase && cmdWr;
  assign strobes.wrSecond = phase && wStage;
  assign strobes.commit   = !phase && wValid;
  assign strobes.outSel   = outSlot ^ outSecond;
  assign strobes.busOe    = busOe;
  assign idx              = cmdIdx;
  assign slot             = cmdSlot;
  assign halfPhase        = phase;

  // R2: phase flips on every edge out of reset
  a_r2_phase_alternates: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (halfPhase != $past(halfPhase)));

  // R4: read data drive opens after a main edge
  a_r4_bus_starts_on_main: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOe) |-> halfPhase);

  // R4: drive lasts for both halves
  a_r4_bus_pair: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOe) |=> busOe);

  // R10: every read taken on a main edge reaches the bus three edges on
  a_r10_read_to_bus: assert property (@(posedge clk) disable iff (!rstN)
    (!halfPhase && !loadN && rdWr) |-> ##3 busOe);

  // R3: every write taken on a main edge is committed four edges on
  a_r3_write_commits: assert property (@(posedge clk) disable iff (!rstN)
    (!halfPhase && !loadN && !rdWr) |-> ##4 strobes.commit);
endmodule

// File: rtl/ddrb2_datapath.sv
module ddrb2_datapath
  import ddrb2_pkg::*;
#(
  parameter int W    = 8,
  parameter int LANE = 4,
  parameter int AW   = 7
) (
  input  logic                clk,
  input  ddrStrobes_t         strobes,
  input  logic [AW-2:0]       idx,
  input  logic                slot,
  input  logic [W-1:0]        dqIn,
  input  logic [W/LANE-1:0]   bwN,
  output logic [W-1:0]        dqOut
);
  localparam int NBW   = W / LANE;
  localparam int NL    = 2 * NBW;
  localparam int WW    = 2 * W;
  localparam int IW    = AW - 1;
  localparam int DEPTH = 1 << IW;

  logic [WW-1:0] mem [DEPTH];
  logic [WW-1:0] wData, oWord, memRd, merged;
  logic [NL-1:0] wMask;
  logic [IW-1:0] wAddr;
  logic          wSlot2;

  assign memRd = mem[idx];

  // forward lanes of the gathered write that the array does not yet hold
  generate
    for (genvar g = 0; g < NL; g++) begin : g_fwd
      assign merged[g*LANE +: LANE] =
        (strobes.commit && (wAddr == idx) && wMask[g]) ? wData[g*LANE +: LANE]
                                                       : memRd[g*LANE +: LANE];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobes.wrFirst) begin
      wAddr                 <= idx;
      wSlot2                <= ~slot;
      wData[slot*W +: W]    <= dqIn;
      wMask[slot*NBW +: NBW] <= ~bwN;
    end
    if (strobes.wrSecond) begin
      wData[wSlot2*W +: W]     <= dqIn;
      wMask[wSlot2*NBW +: NBW] <= ~bwN;
    end
    if (strobes.rdLoad) begin
      oWord <= merged;
    end
    if (strobes.commit) begin
      for (int g = 0; g < NL; g++) begin
        if (wMask[g]) mem[wAddr][g*LANE +: LANE] <= wData[g*LANE +: LANE];
      end
    end
  end

  assign dqOut = strobes.busOe ? oWord[strobes.outSel*W +: W] : '0;
endmodule

// File: rtl/ddr_b2_sram.sv
module ddr_b2_sram
  import ddrb2_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LANE_W     = 4,
  parameter int ADDR_W     = 7,
  parameter int CRIT_FIRST = 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     loadN,
  input  logic                     rdWr,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W/LANE_W-1:0] bwN,
  input  logic [DATA_W-1:0]        dqIn,
  output logic [DATA_W-1:0]        dqOut,
  output logic                     dqOe,
  output logic                     halfPhase
);
  ddrStrobes_t       strobes;
  logic [ADDR_W-2:0] idx;
  logic              slot;

  ddrb2_ctrl #(.AW(ADDR_W), .CRIT_FIRST(CRIT_FIRST)) ctrl_i (
    .clk(clk), .rstN(rstN), .loadN(loadN), .rdWr(rdWr), .addr(addr),
    .strobes(strobes), .idx(idx), .slot(slot), .halfPhase(halfPhase)
  );

  ddrb2_datapath #(.W(DATA_W), .LANE(LANE_W), .AW(ADDR_W)) dp_i (
    .clk(clk), .strobes(strobes), .idx(idx), .slot(slot),
    .dqIn(dqIn), .bwN(bwN), .dqOut(dqOut)
  );

  assign dqOe = strobes.busOe;

  // R1: released bus carries no data
  a_r1_released_bus: assert property (@(posedge clk) disable iff (!rstN)
    !dqOe |-> (dqOut == '0));
endmodule

// File: tb/ddr_b2_sram_tb_top.sv
module ddr_b2_sram_tb_top;
  logic       clk = 1'b0;
  logic       rstN, loadN, rdWr;
  logic [6:0] addr;
  logic [1:0] bwN;
  logic [7:0] dqIn;
  logic [7:0] dqOut, dqOutN;
  logic       dqOe, dqOeN, halfPhase, halfPhaseN;

  always #4 clk = ~clk;

  ddr_b2_sram #(.CRIT_FIRST(1)) dut_i (
    .clk(clk), .rstN(rstN), .loadN(loadN), .rdWr(rdWr), .addr(addr), .bwN(bwN),
    .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe), .halfPhase(halfPhase));

  ddr_b2_sram #(.CRIT_FIRST(0)) dutN (
    .clk(clk), .rstN(rstN), .loadN(loadN), .rdWr(rdWr), .addr(addr), .bwN(bwN),
    .dqIn(dqIn), .dqOut(dqOutN), .dqOe(dqOeN), .halfPhase(halfPhaseN));

  int checks = 0;
  int fails  = 0;
  logic [15:0] model [2][64];

  // pipeline of expectations
  bit         pWr, pRd, ppRd;
  logic [7:0] pD0, pD1;
  logic [1:0] pB0, pB1;
  logic [7:0] pE0 [2];
  logic [7:0] pE1 [2];
  logic [7:0] ppE1 [2];
  string      pTag, ppTag;

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic void modelWrite(logic [6:0] a, logic [7:0] d0, logic [7:0] d1,
                                     logic [1:0] b0, logic [1:0] b1);
    for (int k = 0; k < 2; k++) begin
      int s0 = (k == 0) ? int'(a[0]) : 0;
      for (int t = 0; t < 2; t++) begin
        int s = (t == 0) ? s0 : 1 - s0;
        logic [7:0] d = (t == 0) ? d0 : d1;
        logic [1:0] b = (t == 0) ? b0 : b1;
        for (int j = 0; j < 2; j++)
          if (!b[j]) model[k][a[6:1]][s*8 + j*4 +: 4] = d[j*4 +: 4];
      end
    end
  endfunction

  task automatic outCheck(string tag, bit due, logic [7:0] e [2]);
    if (due) begin
      chk({tag, " R4 oe"}, 8'(dqOe), 8'd1);
      chk({tag, " R5 data"}, dqOut, e[0]);
      chk({tag, " R6 oe"}, 8'(dqOeN), 8'd1);
      chk({tag, " R6 data"}, dqOutN, e[1]);
    end else begin
      chk({tag, " R1 oe"}, 8'(dqOe), 8'd0);
      chk({tag, " R1 bus"}, dqOut, 8'd0);
      chk({tag, " R1 oe"}, 8'(dqOeN), 8'd0);
      chk({tag, " R1 bus"}, dqOutN, 8'd0);
    end
  endtask

  // one main period, entered on the falling edge before a main edge
  task automatic step(bit ld, bit rw, logic [6:0] a, logic [7:0] d0, logic [7:0] d1,
                      logic [1:0] b0, logic [1:0] b1, string tag);
    logic [7:0] n0 [2];
    logic [7:0] n1 [2];
    chk({tag, " R2 phase"}, 8'({halfPhaseN, halfPhase}), 8'd0);
    outCheck({ppTag, " second"}, ppRd, ppE1);
    loadN = !ld;
    rdWr  = rw;
    addr  = a;
    bwN   = pWr ? pB0 : 2'($urandom);
    dqIn  = pWr ? pD0 : 8'($urandom);
    if (ld && !rw) modelWrite(a, d0, d1, b0, b1);
    for (int k = 0; k < 2; k++) begin
      int s0 = (k == 0) ? int'(a[0]) : 0;
      n0[k] = model[k][a[6:1]][s0*8 +: 8];
      n1[k] = model[k][a[6:1]][(1-s0)*8 +: 8];
    end
    @(negedge clk);
    chk({tag, " R2 phase"}, 8'({halfPhaseN, halfPhase}), 8'd3);
    outCheck({pTag, " first"}, pRd, pE0);
    dqIn  = pWr ? pD1 : 8'($urandom);
    bwN   = pWr ? pB1 : 2'($urandom);
    // R2: a command on a half edge must be ignored
    loadN = 1'b0;
    rdWr  = 1'($urandom);
    addr  = 7'($urandom);
    @(negedge clk);
    ppRd = pRd; ppE1 = pE1; ppTag = pTag;
    pRd = ld && rw; pE0 = n0; pE1 = n1; pTag = tag;
    pWr = ld && !rw; pD0 = d0; pD1 = d1; pB0 = b0; pB1 = b1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; loadN = 1'b1; rdWr = 1'b0; addr = '0; bwN = '1; dqIn = '0;
    pWr = 0; pRd = 0; ppRd = 0; pTag = "idle"; ppTag = "idle";
    for (int k = 0; k < 2; k++) begin pE0[k] = 0; pE1[k] = 0; ppE1[k] = 0; end
    repeat (3) @(negedge clk);
    chk("R11 oe", 8'({dqOeN, dqOe}), 8'd0);
    chk("R11 bus", dqOut | dqOutN, 8'd0);
    chk("R11 phase", 8'({halfPhaseN, halfPhase}), 8'd0);
    rstN = 1'b1;

    repeat (3) step(0, 0, 7'($urandom), 8'h00, 8'h00, 2'b00, 2'b00, "R1 deselect");

    // R3 R10: fill every word back to back, start half varied
    for (int i = 0; i < 64; i++)
      step(1, 0, 7'({i[5:0], i[0] ^ i[2]}), 8'(i * 5 + 1), 8'(i ^ 8'hA5),
           2'b00, 2'b00, "R3 R10 fill");

    // R5 R6 R10: read every address, both start halves
    for (int a = 0; a < 128; a++)
      step(1, 1, 7'(a), 8'h00, 8'h00, 2'b00, 2'b00, "R5 R10 sweep");

    // R4: isolated reads release the bus in between
    for (int a = 0; a < 8; a++) begin
      step(1, 1, 7'(a * 9), 8'h00, 8'h00, 2'b00, 2'b00, "R4 single");
      step(0, 1, 7'(a), 8'h00, 8'h00, 2'b00, 2'b00, "R4 gap");
    end

    // R7: every lane-enable combination over both transfers
    for (int m = 0; m < 16; m++) begin
      logic [6:0] a = 7'(m * 7 + 3);
      step(1, 0, a, 8'($urandom), 8'($urandom), 2'(m), 2'(m >> 2), "R7 mask");
      step(0, 0, a, 8'h00, 8'h00, 2'b00, 2'b00, "R7 gap");
      step(1, 1, a, 8'h00, 8'h00, 2'b00, 2'b00, "R7 read");
      step(1, 1, a ^ 7'd1, 8'h00, 8'h00, 2'b00, 2'b00, "R7 read swap");
    end

    // R8: aborted write
    for (int i = 0; i < 4; i++) begin
      logic [6:0] a = 7'(i * 31 + 2);
      step(1, 0, a, 8'hFF, 8'h00, 2'b11, 2'b11, "R8 abort");
      step(1, 1, a, 8'h00, 8'h00, 2'b00, 2'b00, "R8 read");
      step(1, 1, a ^ 7'd1, 8'h00, 8'h00, 2'b00, 2'b00, "R8 read swap");
    end

    // R9: read immediately after a write to the same word
    for (int i = 0; i < 16; i++) begin
      logic [6:0] a = 7'($urandom);
      step(1, 0, a, 8'($urandom), 8'($urandom), 2'(i), 2'(i >> 2), "R9 write");
      step(1, 1, a ^ 7'(i & 1), 8'h00, 8'h00, 2'b00, 2'b00, "R9 forward");
    end
    for (int i = 0; i < 8; i++) begin
      logic [6:0] a = 7'($urandom);
      step(1, 0, a, 8'($urandom), 8'($urandom), 2'b10, 2'b01, "R9 first");
      step(1, 0, a ^ 7'(i & 1), 8'($urandom), 8'($urandom), 2'b01, 2'b10, "R9 second");
      step(1, 1, a, 8'h00, 8'h00, 2'b00, 2'b00, "R9 double");
    end

    repeat (3) step(0, 0, 7'd0, 8'h00, 8'h00, 2'b00, 2'b00, "R4 drain");
    summary();
    $finish;
  end
endmodule